// File: doc/BRIEF.md
# Table-Driven Duty Ramp Sequencer

This block walks a light-pulse channel's duty value through a window of a 64-entry duty table. Software loads the table through a simple write port and then programs the two inclusive window bounds, a step-time code, a direction, and optional looping, ping-pong travel and dwell periods at either end. The block advances on a 1 ms tick from a slow timebase. It presents the current 9-bit duty value on a registered output, which drives the modulator of one channel.

A run begins when both the generator enable and the go control are high, and it stops as soon as either of them drops. Each table entry is shown for a whole number of milliseconds taken from a fixed nonlinear list. The travel can dwell at the end it reaches, for a nonlinear multiple of that step time. A non-looping run raises a done flag and freezes on its last value. The table is written like a block RAM with a synchronous read. The value on the output therefore changes only when the index is loaded, and a table write never alters an output that is already in place.

Top module: `lutramp_sequencer`

## Requirements
- R1: The table holds 64 entries of 9 bits; a write with `tbl_we` high stores `{tbl_msb, tbl_low}` at `tbl_addr`, and values of 256 or more reach `duty_out` with the ninth bit intact.
- R2: When `gen_en` and `ramp_go` are first sampled both high while idle, the index loads `lo_idx` if `ramp_up` is 1, else `hi_idx`; that entry appears on `duty_out` after the second rising edge that follows the sampling edge, and every later index load reaches `duty_out` with the same two-edge latency.
- R3: Step code c (4 bits) selects a hold time of {0,1,2,3,4,6,8,16,18,24,32,36,64,128,256,512}[c] ticks; the index moves only on a clock where `tick_1ms` is high, once that many ticks have been counted.
- R4: Step code 0 never advances the index, so the start entry is held for as long as the run lasts.
- R5: Travel moves one index per step, upward from `lo_idx` to `hi_idx` when `ramp_up` is 1 and downward from `hi_idx` to `lo_idx` when it is 0, and both bounds are shown.
- R6: With `loop_en` set and `pingpong_en` clear, after the end entry has been held (plus any dwell), the index jumps back to the start bound and travel repeats without end.
- R7: With `pingpong_en` set, the direction reverses at each end and the next index is one step back from it, so the end entry is not repeated (when `lo_idx` equals `hi_idx` the index stays). Without `loop_en`, the run finishes on reaching the start bound again, after one round trip.
- R8: When travel reaches `hi_idx` going up (or `lo_idx` going down) and that end's dwell enable is set, the entry is held for a further m × step time, with m from the 6-bit code: codes 0..15 give code+1, and 16..56 give 23, 28, 31, 42, 47, 56, 63, 83, 94, 111, 125, 167, 188, 222, 250, 333, 375, 500, 667, 750, 800, 900, 1000..1600 in steps of 100, 1800, 2000, 2500..6500 in steps of 500, and 7000. Codes above 56 give 7000.
- R9: When a non-looping run ends, `seq_done` goes high and `duty_out` and the index hold; `seq_done` clears on the edge after the run is dropped.
- R10: Dropping `gen_en` or `ramp_go` stops stepping and holds `duty_out`; a new start reloads the start bound.
- R11: A write to the entry being shown leaves `duty_out` unchanged until the next index load.
- R12: After reset `duty_out` is 0 and `seq_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table entry to write |
| tbl_low | input | 8 | Low eight bits of the entry |
| tbl_msb | input | 1 | Ninth bit of the entry |
| lo_idx | input | 6 | Lower window bound (inclusive) |
| hi_idx | input | 6 | Upper window bound (inclusive) |
| step_code | input | 4 | Hold-time code per entry |
| ramp_up | input | 1 | 1: travel low to high, 0: high to low |
| loop_en | input | 1 | Repeat travel indefinitely |
| pingpong_en | input | 1 | Reverse at each end |
| hi_hold_en | input | 1 | Dwell at the upper end |
| hi_hold_code | input | 6 | Dwell multiple code, upper end |
| lo_hold_en | input | 1 | Dwell at the lower end |
| lo_hold_code | input | 6 | Dwell multiple code, lower end |
| gen_en | input | 1 | Generator enable |
| ramp_go | input | 1 | Ramp start control |
| tick_1ms | input | 1 | One-clock pulse per millisecond |
| duty_out | output | 9 | Current duty value |
| seq_done | output | 1 | Non-looping run finished |

## Verification
On every cycle the embedded properties check that the index loads the correct bound on a start and stays inside the window while running. They also check that it never moves on a clock without a tick, and that the done flag appears only at a window end and drops once the run is released. The hold times, the nonlinear dwell multiples up to the 7000 limit, the ping-pong turn without a repeated entry, the round-trip finish and the deferred effect of writing the shown entry only show up over whole runs. For these the bench steps a behavioural reference model on every clock.

// File: rtl/lutramp_pkg.sv
package lutramp_pkg;

  localparam int STEP_CODE_W = 4;
  localparam int HOLD_CODE_W = 6;
  localparam int STEP_MS_W   = 10;
  localparam int HOLD_MULT_W = 13;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_FIN  = 2'd3
  } sq_state_e;

  // hold time per entry, in ticks
  function automatic logic [STEP_MS_W-1:0] step_ms(input logic [STEP_CODE_W-1:0] code);
    logic [STEP_MS_W-1:0] v;
    case (code)
      4'd0:  v = 10'd0;
      4'd1:  v = 10'd1;
      4'd2:  v = 10'd2;
      4'd3:  v = 10'd3;
      4'd4:  v = 10'd4;
      4'd5:  v = 10'd6;
      4'd6:  v = 10'd8;
      4'd7:  v = 10'd16;
      4'd8:  v = 10'd18;
      4'd9:  v = 10'd24;
      4'd10: v = 10'd32;
      4'd11: v = 10'd36;
      4'd12: v = 10'd64;
      4'd13: v = 10'd128;
      4'd14: v = 10'd256;
      default: v = 10'd512;
    endcase
    return v;
  endfunction

  // dwell multiple of the hold time
  function automatic logic [HOLD_MULT_W-1:0] hold_mult(input logic [HOLD_CODE_W-1:0] code);
    logic [HOLD_MULT_W-1:0] v;
    if (code < 6'd16) begin
      v = HOLD_MULT_W'(code) + 1'b1;
    end else begin
      case (code)
        6'd16: v = 13'd23;   6'd17: v = 13'd28;   6'd18: v = 13'd31;
        6'd19: v = 13'd42;   6'd20: v = 13'd47;   6'd21: v = 13'd56;
        6'd22: v = 13'd63;   6'd23: v = 13'd83;   6'd24: v = 13'd94;
        6'd25: v = 13'd111;  6'd26: v = 13'd125;  6'd27: v = 13'd167;
        6'd28: v = 13'd188;  6'd29: v = 13'd222;  6'd30: v = 13'd250;
        6'd31: v = 13'd333;  6'd32: v = 13'd375;  6'd33: v = 13'd500;
        6'd34: v = 13'd667;  6'd35: v = 13'd750;  6'd36: v = 13'd800;
        6'd37: v = 13'd900;  6'd38: v = 13'd1000; 6'd39: v = 13'd1100;
        6'd40: v = 13'd1200; 6'd41: v = 13'd1300; 6'd42: v = 13'd1400;
        6'd43: v = 13'd1500; 6'd44: v = 13'd1600; 6'd45: v = 13'd1800;
        6'd46: v = 13'd2000; 6'd47: v = 13'd2500; 6'd48: v = 13'd3000;
        6'd49: v = 13'd3500; 6'd50: v = 13'd4000; 6'd51: v = 13'd4500;
        6'd52: v = 13'd5000; 6'd53: v = 13'd5500; 6'd54: v = 13'd6000;
        6'd55: v = 13'd6500;
        default: v = 13'd7000;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/lutramp_table.sv
module lutramp_table #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-before-write, synchronous read: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lutramp_timer.sv
module lutramp_timer #(
  parameter int MS_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            tick,
  input  logic [MS_W-1:0] period,
  output logic            step
);
  logic [MS_W-1:0] cnt_q;
  logic [MS_W:0]   cnt_nx;
  logic            hit;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign hit    = (period != '0) && (cnt_nx >= {1'b0, period});
  assign step   = active && tick && hit;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (tick && period != '0) begin
      cnt_q <= hit ? '0 : cnt_nx[MS_W-1:0];
    end
  end
endmodule

// File: rtl/lutramp_seq.sv
module lutramp_seq
  import lutramp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int MULT_W = HOLD_MULT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   up_sel,
  input  logic                   loop_en,
  input  logic                   pp_en,
  input  logic [IDX_W-1:0]       lo_idx,
  input  logic [IDX_W-1:0]       hi_idx,
  input  logic                   hi_hold_en,
  input  logic [HOLD_CODE_W-1:0] hi_hold_code,
  input  logic                   lo_hold_en,
  input  logic [HOLD_CODE_W-1:0] lo_hold_code,
  input  logic                   step,
  output logic [IDX_W-1:0]       idx_q,
  output logic                   load_q,
  output logic                   active,
  output logic                   done_q
);
  sq_state_e         state_q, state_d;
  logic              dir_q, dir_d, leg_q, leg_d;
  logic [IDX_W-1:0]  idx_d;
  logic              load_d;
  logic [MULT_W-1:0] pcnt_q, pcnt_d;
  logic [MULT_W-1:0] mult;
  logic [MULT_W:0]   pcnt_nx;
  logic              at_end, end_hold, finish;

  assign at_end   = dir_q ? (idx_q >= hi_idx) : (idx_q <= lo_idx);
  assign end_hold = dir_q ? hi_hold_en : lo_hold_en;
  assign mult     = MULT_W'(hold_mult(dir_q ? hi_hold_code : lo_hold_code));
  assign pcnt_nx  = {1'b0, pcnt_q} + 1'b1;
  assign active   = (state_q == SQ_RUN) || (state_q == SQ_HOLD);

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    leg_d   = leg_q;
    idx_d   = idx_q;
    pcnt_d  = pcnt_q;
    load_d  = 1'b0;
    finish  = 1'b0;
    if (state_q == SQ_IDLE) begin
      if (run) begin
        idx_d   = up_sel ? lo_idx : hi_idx;
        dir_d   = up_sel;
        leg_d   = 1'b0;
        load_d  = 1'b1;
        state_d = SQ_RUN;
      end
    end else if (!run) begin
      state_d = SQ_IDLE;
    end else if (state_q == SQ_RUN && step) begin
      if (!at_end) begin
        idx_d  = dir_q ? idx_q + 1'b1 : idx_q - 1'b1;
        load_d = 1'b1;
      end else if (end_hold) begin
        state_d = SQ_HOLD;
        pcnt_d  = '0;
      end else begin
        finish = 1'b1;
      end
    end else if (state_q == SQ_HOLD && step) begin
      if (pcnt_nx >= {1'b0, mult}) finish = 1'b1;
      else pcnt_d = pcnt_nx[MULT_W-1:0];
    end

    if (finish) begin
      if (pp_en) begin
        if (!loop_en && leg_q) begin
          state_d = SQ_FIN;
        end else begin
          dir_d   = ~dir_q;
          leg_d   = 1'b1;
          load_d  = 1'b1;
          state_d = SQ_RUN;
          if (lo_idx != hi_idx) idx_d = dir_q ? idx_q - 1'b1 : idx_q + 1'b1;
        end
      end else if (loop_en) begin
        idx_d   = up_sel ? lo_idx : hi_idx;
        dir_d   = up_sel;
        load_d  = 1'b1;
        state_d = SQ_RUN;
      end else begin
        state_d = SQ_FIN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      dir_q   <= 1'b0;
      leg_q   <= 1'b0;
      idx_q   <= '0;
      pcnt_q  <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      leg_q   <= leg_d;
      idx_q   <= idx_d;
      pcnt_q  <= pcnt_d;
      load_q  <= load_d;
      done_q  <= (state_d == SQ_FIN);
    end
  end

  // R2: a start loads the bound picked by the direction
  a_r2_start_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE && run) |=>
      (idx_q == ($past(up_sel) ? $past(lo_idx) : $past(hi_idx))));

  // R5: the index stays inside a stable, well-ordered window
  a_r5_index_in_window: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_IDLE && lo_idx <= hi_idx && $stable(lo_idx) && $stable(hi_idx))
      |-> (idx_q >= lo_idx && idx_q <= hi_idx));

  // R9: done only sits on a window end
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (rst)
    (done_q && lo_idx <= hi_idx && $stable(lo_idx) && $stable(hi_idx))
      |-> (idx_q == lo_idx || idx_q == hi_idx));

  // R9: done clears once the run is released
  a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
    (done_q && !run) |=> !done_q);
endmodule

// File: rtl/lutramp_sequencer.sv
module lutramp_sequencer
  import lutramp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DUTY_W = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_addr,
  input  logic [DUTY_W-2:0]      tbl_low,
  input  logic                   tbl_msb,
  input  logic [IDX_W-1:0]       lo_idx,
  input  logic [IDX_W-1:0]       hi_idx,
  input  logic [STEP_CODE_W-1:0] step_code,
  input  logic                   ramp_up,
  input  logic                   loop_en,
  input  logic                   pingpong_en,
  input  logic                   hi_hold_en,
  input  logic [HOLD_CODE_W-1:0] hi_hold_code,
  input  logic                   lo_hold_en,
  input  logic [HOLD_CODE_W-1:0] lo_hold_code,
  input  logic                   gen_en,
  input  logic                   ramp_go,
  input  logic                   tick_1ms,
  output logic [DUTY_W-1:0]      duty_out,
  output logic                   seq_done
);
  logic              run, step, active, load, pend_q;
  logic [IDX_W-1:0]  idx;
  logic [DUTY_W-1:0] rd_data;

  assign run = gen_en && ramp_go;

  lutramp_table #(.AW(IDX_W), .DW(DUTY_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata ({tbl_msb, tbl_low}),
    .raddr (idx),
    .rdata (rd_data)
  );

  lutramp_timer #(.MS_W(STEP_MS_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .tick   (tick_1ms),
    .period (step_ms(step_code)),
    .step   (step)
  );

  lutramp_seq #(.IDX_W(IDX_W), .MULT_W(HOLD_MULT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .up_sel       (ramp_up),
    .loop_en      (loop_en),
    .pp_en        (pingpong_en),
    .lo_idx       (lo_idx),
    .hi_idx       (hi_idx),
    .hi_hold_en   (hi_hold_en),
    .hi_hold_code (hi_hold_code),
    .lo_hold_en   (lo_hold_en),
    .lo_hold_code (lo_hold_code),
    .step         (step),
    .idx_q        (idx),
    .load_q       (load),
    .active       (active),
    .done_q       (seq_done)
  );

  // the output takes a table value only one read after an index load
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      duty_out <= '0;
    end else begin
      pend_q <= load;
      if (pend_q) duty_out <= rd_data;
    end
  end

  // R3: no tick, no movement of a running index
  a_r3_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
    (active && run && !tick_1ms) |=> $stable(idx));
endmodule

// File: tb/tb_lutramp_sequencer.sv
module tb_lutramp_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       tbl_we = 0, tbl_msb = 0;
  logic [5:0] tbl_addr = 0, lo_idx = 0, hi_idx = 0, hi_hold_code = 0, lo_hold_code = 0;
  logic [7:0] tbl_low = 0;
  logic [3:0] step_code = 0;
  logic       ramp_up = 0, loop_en = 0, pingpong_en = 0, hi_hold_en = 0, lo_hold_en = 0;
  logic       gen_en = 0, ramp_go = 0, tick_1ms = 0;
  logic [8:0] duty_out;
  logic       seq_done;

  int checks = 0, failures = 0, cyc = 0, tdiv = 0;
  bit cmp_en = 0;
  string cur_req = "R12";
  int btbl[64];

  // reference model state
  int m_state, m_idx, m_dir, m_leg, m_tcnt, m_pcnt, m_pend1, m_pend2, m_rd, m_duty, m_done;
  int m_tbl[64];

  lutramp_sequencer dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_low(tbl_low),
    .tbl_msb(tbl_msb), .lo_idx(lo_idx), .hi_idx(hi_idx), .step_code(step_code),
    .ramp_up(ramp_up), .loop_en(loop_en), .pingpong_en(pingpong_en),
    .hi_hold_en(hi_hold_en), .hi_hold_code(hi_hold_code), .lo_hold_en(lo_hold_en),
    .lo_hold_code(lo_hold_code), .gen_en(gen_en), .ramp_go(ramp_go),
    .tick_1ms(tick_1ms), .duty_out(duty_out), .seq_done(seq_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int b_ms(int c);
    int t[16] = '{0, 1, 2, 3, 4, 6, 8, 16, 18, 24, 32, 36, 64, 128, 256, 512};
    return t[c];
  endfunction

  function automatic int b_mult(int c);
    int t[57] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16,
                  23, 28, 31, 42, 47, 56, 63, 83, 94, 111, 125, 167, 188, 222, 250, 333,
                  375, 500, 667, 750, 800, 900, 1000, 1100, 1200, 1300, 1400, 1500, 1600,
                  1800, 2000, 2500, 3000, 3500, 4000, 4500, 5000, 5500, 6000, 6500, 7000};
    if (c > 56) return 7000;
    return t[c];
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one clock of the reference: 0 idle, 1 running, 2 dwelling, 3 finished
  task automatic model_step();
    int n_state, n_idx, n_dir, n_leg, n_tcnt, n_pcnt, n_pend1, n_rd, n_duty;
    int per, hit_end, fin, run, act, stp;
    if (rst) begin
      m_state = 0; m_idx = 0; m_dir = 0; m_leg = 0; m_tcnt = 0; m_pcnt = 0;
      m_pend1 = 0; m_pend2 = 0; m_duty = 0; m_done = 0;
      return;
    end
    n_state = m_state; n_idx = m_idx; n_dir = m_dir; n_leg = m_leg; n_pcnt = m_pcnt;
    n_pend1 = 0; fin = 0;
    n_rd = m_tbl[m_idx];
    n_duty = m_pend2 ? m_rd : m_duty;
    if (tbl_we) m_tbl[tbl_addr] = {tbl_msb, tbl_low};
    run = gen_en && ramp_go;
    act = (m_state == 1 || m_state == 2);
    per = b_ms(step_code);
    stp = tick_1ms && act && per != 0 && (m_tcnt + 1 >= per);
    n_tcnt = m_tcnt;
    if (!act) n_tcnt = 0;
    else if (tick_1ms && per != 0) n_tcnt = stp ? 0 : m_tcnt + 1;
    if (m_state == 0) begin
      if (run) begin
        n_idx = ramp_up ? lo_idx : hi_idx; n_dir = ramp_up; n_leg = 0; n_pend1 = 1; n_state = 1;
      end
    end else if (!run) begin
      n_state = 0;
    end else if (m_state == 1 && stp) begin
      hit_end = m_dir ? (m_idx >= hi_idx) : (m_idx <= lo_idx);
      if (!hit_end) begin
        n_idx = m_dir ? m_idx + 1 : m_idx - 1; n_pend1 = 1;
      end else if (m_dir ? hi_hold_en : lo_hold_en) begin
        n_state = 2; n_pcnt = 0;
      end else fin = 1;
    end else if (m_state == 2 && stp) begin
      if (m_pcnt + 1 >= b_mult(m_dir ? hi_hold_code : lo_hold_code)) fin = 1;
      else n_pcnt = m_pcnt + 1;
    end
    if (fin) begin
      if (pingpong_en) begin
        if (!loop_en && m_leg) n_state = 3;
        else begin
          n_dir = !m_dir; n_leg = 1; n_pend1 = 1; n_state = 1;
          if (lo_idx != hi_idx) n_idx = m_dir ? m_idx - 1 : m_idx + 1;
        end
      end else if (loop_en) begin
        n_idx = ramp_up ? lo_idx : hi_idx; n_dir = ramp_up; n_pend1 = 1; n_state = 1;
      end else n_state = 3;
    end
    m_pend2 = m_pend1; m_rd = n_rd; m_duty = n_duty;
    m_state = n_state; m_idx = n_idx; m_dir = n_dir; m_leg = n_leg;
    m_tcnt = n_tcnt; m_pcnt = n_pcnt; m_pend1 = n_pend1;
    m_done = (n_state == 3);
  endtask

  // compare on every clock, away from the active edge, then advance the model
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (duty_out !== 9'(m_duty) || seq_done !== 1'(m_done)) begin
        failures++;
        $display("FAIL %s cycle-compare actual duty=%0d done=%0d expected duty=%0d done=%0d",
                 cur_req, duty_out, seq_done, m_duty, m_done);
      end
    end
    model_step();
  end

  always @(posedge clk) begin
    #1;
    tick_1ms = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_entry(int a, int v);
    @(posedge clk); #1;
    tbl_we = 1; tbl_addr = 6'(a); tbl_low = 8'(v); tbl_msb = v[8];
    btbl[a] = v;
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  task automatic setup(int lo, int hi, int code, bit up, bit lp, bit pp,
                       bit hpe, int hpc, bit lpe, int lpc);
    @(posedge clk); #1;
    lo_idx = 6'(lo); hi_idx = 6'(hi); step_code = 4'(code); ramp_up = up;
    loop_en = lp; pingpong_en = pp; hi_hold_en = hpe; hi_hold_code = 6'(hpc);
    lo_hold_en = lpe; lo_hold_code = 6'(lpc);
  endtask

  task automatic start_run();
    @(posedge clk); #1;
    gen_en = 1; ramp_go = 1;
  endtask

  task automatic stop_run();
    @(posedge clk); #1;
    gen_en = 0; ramp_go = 0;
    cycles(3);
  endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit && !seq_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int held;
    cycles(4);
    @(negedge clk);
    chk(duty_out == 0, "R12 reset duty", duty_out, 0);
    chk(seq_done == 0, "R12 reset done", seq_done, 0);
    @(posedge clk); #1;
    rst = 0;
    cmp_en = 1;
    cur_req = "R1";
    for (int i = 0; i < 64; i++) write_entry(i, (i * 37 + 5) % 512);

    // single-shot upward travel
    cur_req = "R5";
    setup(3, 7, 1, 1, 0, 0, 0, 0, 0, 0);
    start_run();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(duty_out == btbl[3], "R2 first entry after two edges", duty_out, btbl[3]);
    wait_done(2000);
    chk(seq_done == 1, "R9 done raised", seq_done, 1);
    chk(duty_out == btbl[7], "R5 last entry shown", duty_out, btbl[7]);
    chk(duty_out >= 256, "R1 ninth bit carried", duty_out, btbl[7]);
    cycles(30);
    @(negedge clk);
    chk(duty_out == btbl[7] && seq_done, "R9 held after finish", duty_out, btbl[7]);
    stop_run();
    @(negedge clk);
    chk(seq_done == 0, "R9 done cleared", seq_done, 0);

    // downward looping, timing from step code
    cur_req = "R3/R6";
    setup(10, 13, 2, 0, 1, 0, 0, 0, 0, 0);
    start_run();
    cycles(200);
    @(negedge clk);
    chk(seq_done == 0, "R6 loop never finishes", seq_done, 0);
    stop_run();

    // ping-pong looping with dwell at both ends
    cur_req = "R7/R8";
    setup(20, 23, 1, 1, 1, 1, 1, 2, 1, 0);
    start_run();
    cycles(400);
    stop_run();

    // ping-pong single round trip downward, long dwell at low end
    cur_req = "R7";
    setup(30, 33, 3, 0, 0, 1, 0, 0, 1, 16);
    start_run();
    wait_done(5000);
    chk(seq_done == 1, "R7 round trip finishes", seq_done, 1);
    chk(duty_out == btbl[33], "R7 ends on start bound", duty_out, btbl[33]);
    stop_run();

    // step code 0 holds the first entry
    cur_req = "R4";
    setup(40, 45, 0, 1, 1, 0, 0, 0, 0, 0);
    start_run();
    cycles(200);
    @(negedge clk);
    chk(duty_out == btbl[40], "R4 no advance", duty_out, btbl[40]);
    stop_run();

    // stop by dropping one control, then restart
    cur_req = "R10";
    setup(0, 63, 1, 1, 1, 0, 0, 0, 0, 0);
    start_run();
    cycles(60);
    ramp_go = 0;
    cycles(3);
    @(negedge clk);
    held = duty_out;
    cycles(50);
    @(negedge clk);
    chk(duty_out == held, "R10 output holds when stopped", duty_out, held);
    @(posedge clk); #1;
    ramp_go = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(duty_out == btbl[0], "R10 restart reloads start bound", duty_out, btbl[0]);
    stop_run();

    // write to the shown entry, single-entry loop
    cur_req = "R11";
    setup(50, 50, 5, 1, 1, 0, 0, 0, 0, 0);
    start_run();
    cycles(5);
    held = btbl[50];
    write_entry(50, 427);
    @(negedge clk);
    chk(duty_out == held, "R11 write deferred", duty_out, held);
    cycles(40);
    @(negedge clk);
    chk(duty_out == 427, "R11 new value after next load", duty_out, 427);
    stop_run();

    // top dwell code clamps to 7000
    cur_req = "R8";
    setup(55, 55, 1, 1, 0, 0, 1, 60, 0, 0);
    start_run();
    cycles(26000);
    @(negedge clk);
    chk(seq_done == 0, "R8 still dwelling", seq_done, 0);
    wait_done(4000);
    chk(seq_done == 1, "R8 dwell of 7000 ends", seq_done, 1);
    stop_run();

    // ping-pong on a single-entry window
    cur_req = "R7";
    setup(60, 60, 1, 1, 0, 1, 0, 0, 0, 0);
    start_run();
    wait_done(200);
    chk(seq_done == 1 && duty_out == btbl[60], "R7 single entry round trip",
        duty_out, btbl[60]);
    stop_run();

    summary();
  end
endmodule